// File: doc/BRIEF.md
# Infrared Link Bit-Rate Divider and Receive Bit Recovery

This block serves a serial infrared link whose bits are carried as short pulses. A logic 0 is a pulse in its bit cell and a logic 1 is a cell with no pulse. It runs from a 48 MHz reference clock and has two jobs. The first is to produce a one-cycle transmit bit enable at 1.152 Mb/s or 0.576 Mb/s, chosen by a rate input. The second is to turn the raw optical input into decoded bits, each marked by a one-cycle valid strobe.

Neither rate divides 48 MHz evenly. The transmit path uses a prescaler that averages 10 5/12 clocks. It does this by mixing 10-clock and 11-clock periods, spread out by a phase accumulator. Four prescaler ticks make one bit at the high rate and eight make one bit at the low rate. The receive path samples the input at the full clock rate through a two-flop synchronizer. Its cell counter runs with an average of 41 2/3 clocks per bit, mixing 41-clock and 42-clock cells. Every rising edge on the line restarts the counter, so the decision point stays locked to the sender. At a fixed decision point in each cell, the cell is decoded as 0 if a rising edge was seen in it, and as 1 otherwise.

Top module: `ir_rate_recovery`

## Requirements
- R1: While `rstN` is low (asynchronous reset) or `en` is low, `txBitEn` and `rxBitValid` stay 0. Pulses on `irIn` during that time produce no output.
- R2: With `rateHi`=1, counting the first cycle with `en` high as cycle 0, the first `txBitEn` is in cycle 40. Bit lengths repeat as 41, 42, 42 clocks, which is 125 clocks per three bits. The spacing from the first strobe onward is therefore 42, 42, 41, 42, 42.
- R3: With `rateHi`=0, the first `txBitEn` is in cycle 82. The spacing from it onward is 83, 84, 83, 83, 84, which is 250 clocks per three bits.
- R4: `txBitEn` and `rxBitValid` are never high in two consecutive cycles.
- R5: On a line held low after enabling, every decoded bit is 1 (`rxBit`=1). The first `rxBitValid` is in cycle 21 after `en` rises. Valid strobes then follow at spacings of 41, 42, 42, repeating.
- R6: `irIn` may rise between clock edges 0 and 1. In that case `rxBitValid` is high with `rxBit`=0 in the cycle after edge 24, which covers 2 synchronizer flops, edge detection, 21 counts to the decision point and the output register.
- R7: The R6 latency holds whatever the pulse's phase within the current cell, because the rising edge restarts the cell counter. No valid strobe appears in the cycles after edge 4 and before edge 24.
- R8: A stream of 42-clock cells gives exactly one decoded bit per cell, in order. In that stream, a 0 is a 9-clock high pulse at the cell start and a 1 is a low cell.
- R9: Only the rising transition marks a 0. While the line stays high after a rise, later cells decode as 1.
- R10: While `en` is high, no more than 64 cycles pass without an `rxBitValid` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low holds all counters at zero |
| rateHi | input | 1 | 1 selects 1.152 Mb/s transmit, 0 selects 0.576 Mb/s |
| irIn | input | 1 | Raw infrared receive line, asynchronous |
| txBitEn | output | 1 | One-cycle transmit bit strobe |
| rxBit | output | 1 | Decoded receive bit, meaningful with rxBitValid |
| rxBitValid | output | 1 | One-cycle strobe marking a decoded bit |

## Verification
A wrong phase accumulator shows up within three bit periods. It appears as a transmit spacing or valid spacing that leaves the fixed 41/42 or 83/84 pattern, and the exact interval sequences expose that pattern. A receive counter that fails to restart on a rising edge moves the 24-cycle pulse-to-valid latency. It also adds or drops a decoded bit within one cell, which the phase-offset and stream scenarios catch. A pulse flag that is not cleared at the decision point turns the next idle cell into a spurious 0 one cell later.

// File: rtl/ir_rate_pkg.sv
`timescale 1ns/1ps
package ir_rate_pkg;
  // control -> datapath: which period length the fractional sequencers pick now
  typedef struct packed {
    logic txLong;
    logic rxLong;
  } ctrlStrobes_t;

  // datapath -> control: a period just ended, advance the phase
  typedef struct packed {
    logic preEnd;
    logic cellEnd;
  } dpEvents_t;
endpackage

// File: rtl/ir_frac_phase.sv
`timescale 1ns/1ps
// Spreads NUM long periods evenly over every DEN periods.
module ir_frac_phase #(
  parameter int NUM = 5,
  parameter int DEN = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic adv,
  output logic isLong
);
  localparam int AW = $clog2(NUM + DEN);

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  assign sum    = acc + AW'(NUM);
  assign isLong = (sum >= AW'(DEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      acc <= '0;
    else if (!en)   acc <= '0;
    else if (adv)   acc <= isLong ? (sum - AW'(DEN)) : sum;
  end
endmodule

// File: rtl/ir_rate_ctrl.sv
`timescale 1ns/1ps
module ir_rate_ctrl
  import ir_rate_pkg::*;
#(
  parameter int TX_NUM = 5,
  parameter int TX_DEN = 12,
  parameter int RX_NUM = 2,
  parameter int RX_DEN = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  dpEvents_t    ev,
  output ctrlStrobes_t st
);
  localparam int N_SEQ = 2;
  localparam int SEQ_NUM [N_SEQ] = '{TX_NUM, RX_NUM};
  localparam int SEQ_DEN [N_SEQ] = '{TX_DEN, RX_DEN};

  logic [N_SEQ-1:0] advVec;
  logic [N_SEQ-1:0] longVec;

  assign advVec = {ev.cellEnd, ev.preEnd};

  for (genvar g = 0; g < N_SEQ; g++) begin : g_seq
    ir_frac_phase #(
      .NUM(SEQ_NUM[g]),
      .DEN(SEQ_DEN[g])
    ) u_phase (
      .clk   (clk),
      .rstN  (rstN),
      .en    (en),
      .adv   (advVec[g]),
      .isLong(longVec[g])
    );
  end

  assign st.txLong = longVec[0];
  assign st.rxLong = longVec[1];
endmodule

// File: rtl/ir_rate_dp.sv
`timescale 1ns/1ps
module ir_rate_dp
  import ir_rate_pkg::*;
#(
  parameter int TX_INT        = 10,
  parameter int TICKS_PER_BIT = 4,
  parameter int RX_INT        = 41,
  parameter int RX_DECIDE     = 20,
  parameter int SYNC_STAGES   = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic         rateHi,
  input  logic         irIn,
  input  ctrlStrobes_t st,
  output dpEvents_t    ev,
  output logic         txBitEn,
  output logic         rxBit,
  output logic         rxBitValid
);
  localparam int PW = $clog2(TX_INT + 1);
  localparam int TW = $clog2(2 * TICKS_PER_BIT);
  localparam int CW = $clog2(RX_INT + 1);

  // ---------------- transmit divider ----------------
  logic [PW-1:0] preCnt, preLast;
  logic [TW-1:0] tickCnt, tickLast;
  logic          preEnd, bitEnd;

  assign preLast  = st.txLong ? PW'(TX_INT) : PW'(TX_INT - 1);
  assign preEnd   = en && (preCnt == preLast);
  assign tickLast = rateHi ? TW'(TICKS_PER_BIT - 1) : TW'(2 * TICKS_PER_BIT - 1);
  assign bitEnd   = preEnd && (tickCnt >= tickLast);
  assign txBitEn  = bitEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (!en) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else begin
      preCnt <= preEnd ? '0 : preCnt + 1'b1;
      if (preEnd) tickCnt <= bitEnd ? '0 : tickCnt + 1'b1;
    end
  end

  // ---------------- receive synchronizer and edge ----------------
  logic [SYNC_STAGES:0] syncQ;
  logic                 rise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], irIn};
  end

  assign rise = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // ---------------- receive cell counter and decision ----------------
  logic [CW-1:0] cellCnt, cellLast;
  logic          decide, pulseSeen;

  assign cellLast   = st.rxLong ? CW'(RX_INT) : CW'(RX_INT - 1);
  assign decide     = (cellCnt == CW'(RX_DECIDE));
  assign ev.preEnd  = preEnd;
  assign ev.cellEnd = en && !rise && !decide && (cellCnt == cellLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellCnt    <= '0;
      pulseSeen  <= 1'b0;
      rxBit      <= 1'b0;
      rxBitValid <= 1'b0;
    end else if (!en) begin
      cellCnt    <= '0;
      pulseSeen  <= 1'b0;
      rxBitValid <= 1'b0;
    end else begin
      rxBitValid <= !rise && decide;
      if (rise) begin
        cellCnt   <= '0;
        pulseSeen <= 1'b1;
      end else if (decide) begin
        rxBit     <= ~pulseSeen;
        pulseSeen <= 1'b0;
        cellCnt   <= cellCnt + 1'b1;
      end else if (ev.cellEnd) begin
        cellCnt <= '0;
      end else begin
        cellCnt <= cellCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_rate_recovery.sv
`timescale 1ns/1ps
module ir_rate_recovery
  import ir_rate_pkg::*;
#(
  parameter int TX_INT        = 10,
  parameter int TX_NUM        = 5,
  parameter int TX_DEN        = 12,
  parameter int TICKS_PER_BIT = 4,
  parameter int RX_INT        = 41,
  parameter int RX_NUM        = 2,
  parameter int RX_DEN        = 3,
  parameter int RX_DECIDE     = 20,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic rateHi,
  input  logic irIn,
  output logic txBitEn,
  output logic rxBit,
  output logic rxBitValid
);
  ctrlStrobes_t st;
  dpEvents_t    ev;

  ir_rate_ctrl #(
    .TX_NUM(TX_NUM), .TX_DEN(TX_DEN),
    .RX_NUM(RX_NUM), .RX_DEN(RX_DEN)
  ) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .en  (en),
    .ev  (ev),
    .st  (st)
  );

  ir_rate_dp #(
    .TX_INT(TX_INT), .TICKS_PER_BIT(TICKS_PER_BIT),
    .RX_INT(RX_INT), .RX_DECIDE(RX_DECIDE), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .en        (en),
    .rateHi    (rateHi),
    .irIn      (irIn),
    .st        (st),
    .ev        (ev),
    .txBitEn   (txBitEn),
    .rxBit     (rxBit),
    .rxBitValid(rxBitValid)
  );
endmodule

// File: rtl/ir_rate_recovery_chk.sv
`timescale 1ns/1ps
module ir_rate_recovery_chk (
  input logic clk,
  input logic rstN,
  input logic en,
  input logic rateHi,
  input logic irIn,
  input logic txBitEn,
  input logic rxBit,
  input logic rxBitValid
);
  logic [7:0] txGap, rxGap, steadyCnt;
  logic       txSeen, rateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txGap <= '0; rxGap <= '0; steadyCnt <= '0; txSeen <= 1'b0; rateQ <= 1'b0;
    end else begin
      rateQ <= rateHi;
      if (!en) begin
        txGap <= '0; rxGap <= '0; steadyCnt <= '0; txSeen <= 1'b0;
      end else begin
        txGap     <= txBitEn ? 8'd1 : (txGap == 8'hFF ? txGap : txGap + 8'd1);
        rxGap     <= rxBitValid ? 8'd1 : (rxGap == 8'hFF ? rxGap : rxGap + 8'd1);
        steadyCnt <= (rateHi != rateQ) ? 8'd0 : (steadyCnt == 8'hFF ? steadyCnt : steadyCnt + 8'd1);
        if (txBitEn) txSeen <= 1'b1;
      end
    end
  end

  // R1
  rx_quiet_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !rxBitValid);

  // R4
  tx_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    txBitEn |=> !txBitEn);

  // R4
  rx_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxBitValid |=> !rxBitValid);

  // R2 R3
  tx_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBitEn && txSeen && steadyCnt >= 8'd100) |->
      (rateHi ? (txGap == 8'd41 || txGap == 8'd42) : (txGap == 8'd83 || txGap == 8'd84)));

  // R10
  rx_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    en |-> rxGap <= 8'd64);
endmodule

bind ir_rate_recovery ir_rate_recovery_chk u_chk (
  .clk(clk), .rstN(rstN), .en(en), .rateHi(rateHi), .irIn(irIn),
  .txBitEn(txBitEn), .rxBit(rxBit), .rxBitValid(rxBitValid)
);

// File: tb/test_ir_rate_recovery.sv
`timescale 1ns/1ps
module test_ir_rate_recovery;
  logic clk = 1'b0, rstN = 1'b0, en = 1'b0, rateHi = 1'b1, irIn = 1'b0;
  logic txBitEn, rxBit, rxBitValid;
  int   nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  ir_rate_recovery i_ir_rate_recovery (
    .clk(clk), .rstN(rstN), .en(en), .rateHi(rateHi), .irIn(irIn),
    .txBitEn(txBitEn), .rxBit(rxBit), .rxBitValid(rxBitValid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk); en = 1'b0; irIn = 1'b0;
    repeat (6) @(negedge clk);
    en = 1'b1;   // this negedge starts cycle 0
  endtask

  // R1: reset and disable
  task automatic t_reset_disable();
    int seen = 0;
    chk(txBitEn == 0 && rxBitValid == 0, "R1 reset outputs", {txBitEn, rxBitValid}, 0);
    @(negedge clk); rstN = 1'b1;
    en = 1'b0;
    for (int k = 0; k < 300; k++) begin
      irIn = (k % 42) < 9;
      @(negedge clk);
      if (txBitEn || rxBitValid) seen++;
    end
    irIn = 1'b0;
    chk(seen == 0, "R1 disabled strobes", seen, 0);
  endtask

  // R2 / R3: transmit spacing
  task automatic t_tx(input bit hi);
    int pos[6];
    int n = 0;
    int exp1[5] = '{42, 42, 41, 42, 42};
    int exp0[5] = '{83, 84, 83, 83, 84};
    string req = hi ? "R2" : "R3";
    int wide = 0;
    rateHi = hi;
    restart();
    for (int k = 0; k < 600 && n < 6; k++) begin
      @(negedge clk);
      if (txBitEn) begin
        pos[n] = k + 1;
        n++;
        @(negedge clk); k++;
        if (txBitEn) wide++;
      end
    end
    chk(n == 6, req, n, 6);
    chk(pos[0] == (hi ? 40 : 82), {req, " first strobe"}, pos[0], hi ? 40 : 82);
    for (int i = 0; i < 5; i++)
      chk(pos[i+1] - pos[i] == (hi ? exp1[i] : exp0[i]), {req, " spacing"},
          pos[i+1] - pos[i], hi ? exp1[i] : exp0[i]);
    chk(wide == 0, "R4 tx strobe width", wide, 0);
  endtask

  // R5: idle line
  task automatic t_rx_idle();
    int pos[5];
    int n = 0, zeros = 0;
    int expGap[4] = '{41, 42, 42, 41};
    restart();
    for (int k = 1; k <= 200 && n < 5; k++) begin
      @(negedge clk);
      if (rxBitValid) begin
        pos[n] = k; n++;
        if (rxBit != 1'b1) zeros++;
      end
    end
    chk(n == 5, "R5 count", n, 5);
    chk(pos[0] == 21, "R5 first valid", pos[0], 21);
    for (int i = 0; i < 4; i++)
      chk(pos[i+1] - pos[i] == expGap[i], "R5 spacing", pos[i+1] - pos[i], expGap[i]);
    chk(zeros == 0, "R5 idle bits", zeros, 0);
  endtask

  // R6 / R7: pulse latency at several cell phases
  task automatic t_rx_latency(input int offset);
    int zeroAt = -1, stray = 0, extraZero = 0;
    restart();
    repeat (offset) @(negedge clk);
    irIn = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 6) irIn = 1'b0;
      if (rxBitValid) begin
        if (rxBit == 1'b0) begin
          if (zeroAt < 0) zeroAt = k; else extraZero++;
        end else if (k >= 4 && k < 24) stray++;
      end
    end
    chk(zeroAt == 24, "R6 pulse to valid latency", zeroAt, 24);
    chk(stray == 0 && extraZero == 0, "R7 no extra valid at this phase", stray + extraZero, 0);
  endtask

  // R8: stream of 42-clock cells
  task automatic t_rx_stream();
    bit pattern[12] = '{0, 1, 1, 0, 0, 1, 0, 1, 1, 1, 0, 1};
    bit got[16];
    int n = 0, bad = 0;
    restart();
    for (int c = 0; c < 12; c++) begin
      for (int k = 0; k < 42; k++) begin
        irIn = (pattern[c] == 1'b0) && (k < 9);
        @(negedge clk);
        if (rxBitValid) begin
          if (n < 16) got[n] = rxBit;
          n++;
        end
      end
    end
    irIn = 1'b0;
    chk(n == 12, "R8 bits per cell", n, 12);
    for (int i = 0; i < 12; i++)
      if (i < n && got[i] != pattern[i]) bad++;
    chk(bad == 0, "R8 decoded order", bad, 0);
  endtask

  // R9: line held high
  task automatic t_rx_level();
    int n = 0, zeros = 0, firstBit = -1;
    restart();
    irIn = 1'b1;
    for (int k = 1; k <= 130; k++) begin
      @(negedge clk);
      if (rxBitValid) begin
        if (firstBit < 0) firstBit = rxBit;
        else if (rxBit == 1'b0) zeros++;
        n++;
      end
    end
    irIn = 1'b0;
    chk(firstBit == 0, "R9 first bit is zero", firstBit, 0);
    chk(n >= 3 && zeros == 0, "R9 held high decodes ones", zeros, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_disable();
    t_tx(1'b1);
    t_tx(1'b0);
    rateHi = 1'b1;
    t_rx_idle();
    t_rx_latency(7);
    t_rx_latency(30);
    t_rx_latency(55);
    t_rx_stream();
    t_rx_level();
    restart();
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
    chk(txBitEn == 0 && rxBitValid == 0, "R1 after disable", {txBitEn, rxBitValid}, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule